// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block lets several harts share one word-addressed memory and build lock-free updates on it with load-reserved and store-conditional accesses. Each hart keeps a private reservation made of a valid flag and a word address. A load-reserved reads the addressed word and records that address as the hart's reservation. A later store-conditional writes only if that reservation is still valid and names the same address. Each store-conditional reports a pass/fail status.

A store-conditional that succeeds cancels every reservation other harts hold on that word. A plain store cancels every reservation on the word it writes. Any store-conditional also drops the issuing hart's own reservation, whether it passes or fails.

Every hart has its own request port. Requests that arrive together are served one per cycle, lowest hart index first. A hart keeps its request asserted until it sees its grant. A response pulse, with the read word and the updated status, follows each grant by one cycle.

Top module: `resv_monitor`

## Requirements
- R1: At most one hart is granted per cycle, and it is the lowest-indexed hart with `reqValid` set. A hart that is not granted keeps its request asserted and is served in a later cycle.
- R2: `respValid[i]` pulses in the cycle after hart i is granted, and only then.
- R3: A load (op 2'b00) or load-reserved (op 2'b10) returns the addressed word on `respData` with the response. A load-reserved also sets the hart's reservation flag and records the target address.
- R4: A new load-reserved replaces any earlier reservation of the same hart. A store-conditional to the older address then fails.
- R5: A store-conditional (op 2'b11) whose hart holds a valid reservation on the same address writes its data and sets `scFail[i]` to 0.
- R6: A store-conditional with no valid reservation, or with a reservation on a different address, leaves memory unchanged and sets `scFail[i]` to 1.
- R7: Every store-conditional clears the issuing hart's reservation, so a second store-conditional without a new load-reserved fails.
- R8: A successful store-conditional cancels other harts' reservations on the same address. Reservations on other addresses are kept.
- R9: A plain store (op 2'b01) writes its data and cancels all reservations on that address.
- R10: Requests granted in successive cycles see each other's effects in grant order. For example, when two harts store-conditional the same reserved word together, the lower index succeeds and the higher fails.
- R11: After reset, every memory word reads 0, no reservation is held, `scFail` is all 0 and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_HARTS | Per-hart request valid |
| reqOp | input | NUM_HARTS x 2 | Per-hart operation: 00 load, 01 store, 10 load-reserved, 11 store-conditional |
| reqAddr | input | NUM_HARTS x ADDR_W | Per-hart word address |
| reqData | input | NUM_HARTS x DATA_W | Per-hart write data |
| grant | output | NUM_HARTS | One-hot grant for the request served this cycle |
| respValid | output | NUM_HARTS | Response pulse, one cycle after grant |
| respData | output | DATA_W | Word read by the served request |
| scFail | output | NUM_HARTS | Per-hart status of its latest store-conditional: 0 pass, 1 fail |

## Verification
Two collisions can happen in one cycle: several harts present requests, and a store-conditional races against a load-reserved or store by another hart on the same word. The bench presents two load-reserveds to one word in the same cycle, then two store-conditionals to that word in the same cycle. It expects the lower hart to win and the higher hart to see a failure status. It also presents a plain store and a store-conditional to one reserved word in the same cycle. A reference model applies the requests in priority order, and each response is compared against it in the order the grants occur.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LR    = 2'b10,
    OP_SC    = 2'b11
  } memOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic access;
    logic write;
  } dpStrobe_t;
endpackage

// File: rtl/resv_arbiter.sv
module resv_arbiter #(
  parameter int NUM_HARTS = 4,
  localparam int IDX_W = $clog2(NUM_HARTS)
) (
  input  logic [NUM_HARTS-1:0] reqValid,
  output logic [NUM_HARTS-1:0] grant,
  output logic [IDX_W-1:0]     grantIdx,
  output logic                 anyGrant
);
  always_comb begin
    grant    = '0;
    grantIdx = '0;
    for (int i = NUM_HARTS - 1; i >= 0; i--) begin
      if (reqValid[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        grantIdx = IDX_W'(i);
      end
    end
    anyGrant = |reqValid;
  end
endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 6,
  localparam int IDX_W    = $clog2(NUM_HARTS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_HARTS-1:0]              grant,
  input  logic [IDX_W-1:0]                  grantIdx,
  input  logic                              anyGrant,
  input  logic [NUM_HARTS-1:0][1:0]         reqOp,
  input  logic [NUM_HARTS-1:0][ADDR_W-1:0]  reqAddr,
  output dpStrobe_t                         strobe,
  output logic [NUM_HARTS-1:0]              rsvValid,
  output logic [NUM_HARTS-1:0][ADDR_W-1:0]  rsvAddr,
  output logic [NUM_HARTS-1:0]              respValid,
  output logic [NUM_HARTS-1:0]              scFail
);
  memOp_e            curOp;
  logic [ADDR_W-1:0] curAddr;
  logic              scHit;

  always_comb begin
    curOp   = memOp_e'(reqOp[grantIdx]);
    curAddr = reqAddr[grantIdx];
    scHit   = rsvValid[grantIdx] && (rsvAddr[grantIdx] == curAddr);
    strobe.access = anyGrant;
    strobe.write  = anyGrant && ((curOp == OP_STORE) || ((curOp == OP_SC) && scHit));
  end

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_rsv
    logic isMine;
    assign isMine = anyGrant && (grantIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsvValid[i] <= 1'b0;
        rsvAddr[i]  <= '0;
        scFail[i]   <= 1'b0;
      end else begin
        if (isMine && curOp == OP_LR) begin
          rsvValid[i] <= 1'b1;
          rsvAddr[i]  <= curAddr;
        end else if (isMine && curOp == OP_SC) begin
          rsvValid[i] <= 1'b0;
        end else if (strobe.write && rsvAddr[i] == curAddr) begin
          rsvValid[i] <= 1'b0;
        end
        if (isMine && curOp == OP_SC) begin
          scFail[i] <= !scHit;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) respValid <= '0;
    else        respValid <= grant;
  end
endmodule

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_HARTS),
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  dpStrobe_t                         strobe,
  input  logic [IDX_W-1:0]                  grantIdx,
  input  logic [NUM_HARTS-1:0][ADDR_W-1:0]  reqAddr,
  input  logic [NUM_HARTS-1:0][DATA_W-1:0]  reqData,
  output logic [DATA_W-1:0]                 rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] selAddr;
  logic [DATA_W-1:0] selData;

  assign selAddr = reqAddr[grantIdx];
  assign selData = reqData[grantIdx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      rdData <= '0;
    end else begin
      if (strobe.access) rdData <= mem[selAddr];
      if (strobe.write)  mem[selAddr] <= selData;
    end
  end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_HARTS-1:0]              reqValid,
  input  logic [NUM_HARTS-1:0][1:0]         reqOp,
  input  logic [NUM_HARTS-1:0][ADDR_W-1:0]  reqAddr,
  input  logic [NUM_HARTS-1:0][DATA_W-1:0]  reqData,
  output logic [NUM_HARTS-1:0]              grant,
  output logic [NUM_HARTS-1:0]              respValid,
  output logic [DATA_W-1:0]                 respData,
  output logic [NUM_HARTS-1:0]              scFail
);
  localparam int IDX_W = $clog2(NUM_HARTS);

  logic [IDX_W-1:0]                 grantIdx;
  logic                             anyGrant;
  dpStrobe_t                        strobe;
  logic [NUM_HARTS-1:0]             rsvValid;
  logic [NUM_HARTS-1:0][ADDR_W-1:0] rsvAddr;

  resv_arbiter #(.NUM_HARTS(NUM_HARTS)) u_arb (
    .reqValid(reqValid), .grant(grant), .grantIdx(grantIdx), .anyGrant(anyGrant)
  );

  resv_ctrl #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .grant(grant), .grantIdx(grantIdx),
    .anyGrant(anyGrant), .reqOp(reqOp), .reqAddr(reqAddr), .strobe(strobe),
    .rsvValid(rsvValid), .rsvAddr(rsvAddr), .respValid(respValid), .scFail(scFail)
  );

  resv_datapath #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .grantIdx(grantIdx),
    .reqAddr(reqAddr), .reqData(reqData), .rdData(respData)
  );
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 6
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_HARTS-1:0]              reqValid,
  input logic [NUM_HARTS-1:0][1:0]         reqOp,
  input logic [NUM_HARTS-1:0][ADDR_W-1:0]  reqAddr,
  input logic [NUM_HARTS-1:0]              grant,
  input logic [NUM_HARTS-1:0]              respValid,
  input logic [NUM_HARTS-1:0]              scFail,
  input logic [NUM_HARTS-1:0]              rsvValid,
  input logic [NUM_HARTS-1:0][ADDR_W-1:0]  rsvAddr
);
  p_single_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_h
    logic [NUM_HARTS-1:0] lowMask;
    logic                 ownMatch;
    assign lowMask  = NUM_HARTS'((1 << i) - 1);
    assign ownMatch = rsvValid[i] && (rsvAddr[i] == reqAddr[i]);

    p_priority_r1: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> ((reqValid & lowMask) == '0));

    p_resp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |=> respValid[i]);

    p_resp_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !grant[i] |=> !respValid[i]);

    p_lr_records_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && reqOp[i] == 2'b10) |=> (rsvValid[i] && rsvAddr[i] == $past(reqAddr[i])));

    p_sc_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && reqOp[i] == 2'b11 && ownMatch) |=> !scFail[i]);

    p_sc_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && reqOp[i] == 2'b11 && !ownMatch) |=> scFail[i]);

    p_sc_drops_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[i] && reqOp[i] == 2'b11) |=> !rsvValid[i]);
  end
endmodule

bind resv_monitor resv_monitor_chk #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
  .grant(grant), .respValid(respValid), .scFail(scFail),
  .rsvValid(rsvValid), .rsvAddr(rsvAddr)
);

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;
  localparam int NH = 4;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NH-1:0]         reqValid = '0;
  logic [NH-1:0][1:0]    reqOp = '0;
  logic [NH-1:0][AW-1:0] reqAddr = '0;
  logic [NH-1:0][DW-1:0] reqData = '0;
  logic [NH-1:0]         grant;
  logic [NH-1:0]         respValid;
  logic [DW-1:0]         respData;
  logic [NH-1:0]         scFail;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  resv_monitor #(.NUM_HARTS(NH), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .grant(grant), .respValid(respValid), .respData(respData),
    .scFail(scFail)
  );

  // reference model
  logic [DW-1:0] mdl [1 << AW];
  bit            mrv [NH];
  int            mra [NH];

  // scoreboard queues
  int            qHart[$];
  bit            qChkData[$];
  logic [DW-1:0] qData[$];
  bit            qChkFail[$];
  bit            qFail[$];
  string         qTag[$];

  // pending batch
  logic [NH-1:0] bMask = '0;
  logic [1:0]    bOp   [NH];
  int            bAddr [NH];
  logic [DW-1:0] bData [NH];
  string         bTag  [NH];

  task automatic pushExp(int h, bit cd, logic [DW-1:0] d, bit cf, bit f, string tag);
    qHart.push_back(h); qChkData.push_back(cd); qData.push_back(d);
    qChkFail.push_back(cf); qFail.push_back(f); qTag.push_back(tag);
  endtask

  task automatic modelApply(int h);
    int a;
    bit hit;
    a = bAddr[h];
    case (bOp[h])
      2'b00: pushExp(h, 1, mdl[a], 0, 0, bTag[h]);
      2'b01: begin
        mdl[a] = bData[h];
        for (int k = 0; k < NH; k++) if (mra[k] == a) mrv[k] = 0;
        pushExp(h, 0, '0, 0, 0, bTag[h]);
      end
      2'b10: begin
        pushExp(h, 1, mdl[a], 0, 0, bTag[h]);
        mrv[h] = 1; mra[h] = a;
      end
      default: begin
        hit = mrv[h] && (mra[h] == a);
        if (hit) begin
          mdl[a] = bData[h];
          for (int k = 0; k < NH; k++) if (mra[k] == a) mrv[k] = 0;
        end
        mrv[h] = 0;
        pushExp(h, 0, '0, 1, !hit, bTag[h]);
      end
    endcase
  endtask

  task automatic setReq(int h, logic [1:0] op, int a, logic [DW-1:0] d, string tag);
    bMask[h] = 1'b1; bOp[h] = op; bAddr[h] = a; bData[h] = d; bTag[h] = tag;
  endtask

  task automatic runBatch();
    logic [NH-1:0] pending;
    logic [NH-1:0] low;
    @(negedge clk);
    for (int h = 0; h < NH; h++) begin
      if (bMask[h]) begin
        modelApply(h);
        reqOp[h]   = bOp[h];
        reqAddr[h] = AW'(bAddr[h]);
        reqData[h] = bData[h];
      end
    end
    pending  = bMask;
    reqValid = pending;
    while (pending != '0) begin
      #1;
      low = pending & (~pending + 1'b1);
      checks++;
      if (grant !== low) begin
        errors++;
        $display("FAIL R1 grant actual %b expected %b", grant, low);
      end
      @(posedge clk);
      @(negedge clk);
      pending  = pending & ~low;
      reqValid = pending;
    end
    bMask = '0;
  endtask

  task automatic one(int h, logic [1:0] op, int a, logic [DW-1:0] d, string tag);
    setReq(h, op, a, d, tag);
    runBatch();
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rst_n && respValid != '0) begin
      if (qHart.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected response actual %b expected none", respValid);
      end else begin
        int h;
        string tag;
        h = qHart.pop_front();
        tag = qTag.pop_front();
        checks++;
        if (respValid !== NH'(1 << h)) begin
          errors++;
          $display("FAIL R2 respValid actual %b expected %b", respValid, NH'(1 << h));
        end
        if (qChkData.pop_front()) begin
          logic [DW-1:0] e;
          e = qData.pop_front();
          checks++;
          if (respData !== e) begin
            errors++;
            $display("FAIL %s hart %0d data actual %h expected %h", tag, h, respData, e);
          end
        end else void'(qData.pop_front());
        if (qChkFail.pop_front()) begin
          bit f;
          f = qFail.pop_front();
          checks++;
          if (scFail[h] !== f) begin
            errors++;
            $display("FAIL %s hart %0d scFail actual %b expected %b", tag, h, scFail[h], f);
          end
        end else void'(qFail.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < (1 << AW); k++) mdl[k] = '0;
    for (int k = 0; k < NH; k++) begin mrv[k] = 0; mra[k] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (respValid !== '0 || scFail !== '0) begin
      errors++;
      $display("FAIL R11 reset outputs actual %b/%b expected 0/0", respValid, scFail);
    end
    rst_n = 1'b1;

    one(2, 2'b00, 33, '0, "R11");                 // memory reads 0 after reset
    one(0, 2'b01, 5, 32'h11, "R9");
    one(1, 2'b00, 5, '0, "R3");
    one(0, 2'b10, 5, '0, "R3");
    one(0, 2'b11, 5, 32'h22, "R5");
    one(3, 2'b00, 5, '0, "R5");
    one(0, 2'b11, 5, 32'h33, "R7");               // reservation already dropped
    one(3, 2'b00, 5, '0, "R7");
    one(1, 2'b11, 7, 32'h44, "R6");               // no reservation
    one(1, 2'b10, 7, '0, "R3");
    one(1, 2'b11, 8, 32'h55, "R6");               // wrong address
    one(2, 2'b00, 8, '0, "R6");
    one(1, 2'b10, 3, '0, "R4");
    one(1, 2'b10, 4, '0, "R4");
    one(1, 2'b11, 3, 32'h66, "R4");               // old address no longer reserved
    one(0, 2'b10, 9, '0, "R8");
    one(2, 2'b10, 9, '0, "R8");
    one(3, 2'b10, 10, '0, "R8");
    one(0, 2'b11, 9, 32'h77, "R8");
    one(2, 2'b11, 9, 32'h88, "R8");               // cancelled by hart 0
    one(3, 2'b11, 10, 32'h99, "R8");              // other address kept
    one(1, 2'b00, 9, '0, "R8");
    one(1, 2'b10, 12, '0, "R9");
    one(2, 2'b01, 12, 32'hAA, "R9");
    one(1, 2'b11, 12, 32'hBB, "R9");
    one(1, 2'b00, 12, '0, "R9");

    // same-cycle collisions
    setReq(0, 2'b10, 20, '0, "R10");
    setReq(1, 2'b10, 20, '0, "R10");
    runBatch();
    setReq(1, 2'b11, 20, 32'hC1, "R10");
    setReq(0, 2'b11, 20, 32'hC0, "R10");
    runBatch();
    setReq(3, 2'b10, 21, '0, "R10");
    runBatch();
    setReq(2, 2'b01, 21, 32'hD2, "R10");
    setReq(3, 2'b11, 21, 32'hD3, "R10");
    runBatch();
    for (int h = 0; h < NH; h++) setReq(h, 2'b00, h == 0 ? 20 : 21, '0, "R1");
    runBatch();
    setReq(3, 2'b10, 22, '0, "R1");
    setReq(2, 2'b01, 22, 32'hE2, "R1");
    runBatch();
    one(3, 2'b11, 22, 32'hE3, "R9");

    repeat (3) @(negedge clk);
    checks++;
    if (qHart.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses actual %0d expected 0", qHart.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule